// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave that lets an external controller read and write a bank of byte-wide configuration registers over a four-signal serial link. The signals are an active-low select, a serial clock, a data input and a data output. The block runs entirely on the serial clock. Each access is a 24-bit word sent most significant bit first. The word holds a read flag, a marker bit that must be 1, a 14-bit register address and one data byte. The controller may pack any number of whole words into one select window. Bits left over at the end of a window are dropped.

The register bank has a default value for every entry. An asynchronous hardware reset input restores the defaults, and so does a self-clearing software reset bit inside the bank. For a read, the block shifts the addressed byte out during the data byte of the same word. It updates the output on falling clock edges so that the controller can sample on rising edges. When the block is not driving the line, it lowers an output-enable signal for the pad, which then floats. The whole bank is also presented as a flat vector for the surrounding logic.

Top module: `scfg_top`

## Requirements
- R1: Input bits are taken only on rising edges of `sclk` while `sen_n` is low. Toggling `sdi` while `sen_n` is high changes nothing.
- R2: Word bit order is fixed. First comes the read flag (0 = write), then the marker, then address bits 13..0, then data bits 7..0. A write takes effect at the 24th rising edge of the word.
- R3: Several complete 24-bit words inside one select window are each applied in order.
- R4: Bits left over that do not finish a word when `sen_n` rises are discarded without a write. The next window starts again at the first bit.
- R5: A word whose marker bit (second bit) is 0 has no effect.
- R6: In a read word with marker 1, bits 7..0 of the addressed register appear on `sdo` with `sdo_oe` high. Each bit changes on the falling edge that follows rising edges 16 to 23 of the word.
- R7: A word with the read flag set never writes. The flag stays set until a word starting with 0 clears it, and that word then writes normally.
- R8: `sdo_oe` is low whenever no read data is being shifted out: in write words, during the address part, and while `sen_n` is high.
- R9: Writing a byte with bit 0 set to address 6 restores every register to its default value, and bit 0 of address 6 then reads 0.
- R10: While `hw_rst` is high, every register holds its default (0x3C at address 3, 0 elsewhere with the default parameters), and `sdo_oe` is low.
- R11: Addresses at or above the bank size are not decoded. Writes to them change nothing, including writes whose low bits match address 6. Reads from them shift out zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hw_rst | input | 1 | Asynchronous active-high reset to register defaults |
| sen_n | input | 1 | Active-low select; a high level clears the bit counter |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising edges |
| sdo | output | 1 | Serial read data, updated on falling edges |
| sdo_oe | output | 1 | Pad output enable for `sdo`; low means high-impedance |
| cfg_regs | output | NREG*DATA_W | All registers, address 0 in the low byte |

## Verification
A register write becomes visible on `cfg_regs` right after the 24th rising edge of its word. The bench compares the whole bank with its model on every falling edge, half a period after any update. A readback bit for word bit position k (16..23) is driven on the falling edge before rising edge k, so the bench samples `sdo` and `sdo_oe` a quarter period after that falling edge. The check for the enable going low after a window is made a quarter period after `sen_n` rises. After a hardware reset pulse, the defaults are checked on the first falling edge after release.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

   localparam int unsigned RW_FLAG_BITS = 1;
   localparam int unsigned MARK_BITS    = 1;

   // header = read flag + marker + address
   function automatic int unsigned hdr_width(input int unsigned aw);
      return RW_FLAG_BITS + MARK_BITS + aw;
   endfunction

   function automatic int unsigned word_width(input int unsigned aw, input int unsigned dw);
      return hdr_width(aw) + dw;
   endfunction

   // source of the serial output in the data phase
   typedef enum logic [1:0] {
      DRV_OFF  = 2'd0,
      DRV_REG  = 2'd1,
      DRV_HOLE = 2'd2
   } drv_e;

endpackage

// File: rtl/scfg_shift.sv
module scfg_shift
   import scfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned HDR_W  = hdr_width(ADDR_W),
   localparam int unsigned WORD_W = word_width(ADDR_W, DATA_W),
   localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
   input  logic              hw_rst,
   input  logic              sen_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [CNT_W-1:0]  cnt,
   output logic [HDR_W-1:0]  hdr_q,
   output logic              rd_mode,
   output logic              word_done,
   output logic [WORD_W-1:0] word
);

   localparam logic [CNT_W-1:0] LAST    = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_W - 1);

   logic              clr;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-2:0] shreg_q;
   logic              rd_mode_q;

   // select high (or hardware reset) forces the next window to bit 0
   assign clr = hw_rst | sen_n;

   always_ff @(posedge sclk or posedge clr) begin
      if (clr) begin
         cnt_q   <= '0;
         shreg_q <= '0;
         hdr_q   <= '0;
      end else begin
         shreg_q <= {shreg_q[WORD_W-3:0], sdi};
         cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         if (cnt_q == HDR_END)
            hdr_q <= {shreg_q[HDR_W-2:0], sdi};
      end
   end

   // sticky read flag: follows the first bit of every word
   always_ff @(posedge sclk or posedge hw_rst) begin
      if (hw_rst)
         rd_mode_q <= 1'b0;
      else if (!sen_n && cnt_q == '0)
         rd_mode_q <= sdi;
   end

   assign cnt       = cnt_q;
   assign rd_mode   = rd_mode_q;
   assign word_done = !sen_n && (cnt_q == LAST);
   assign word      = {shreg_q, sdi};

   // R4
   idle_cnt_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      sen_n |-> (cnt_q == '0));

   // R2
   hdr_sync_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      word_done |-> (hdr_q == word[WORD_W-1 -: HDR_W]));

endmodule

// File: rtl/scfg_regs.sv
module scfg_regs #(
   parameter int unsigned NREG    = 16,
   parameter int unsigned ADDR_W  = 14,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned RST_IDX = 6,
   parameter int unsigned RST_BIT = 0,
   parameter logic [NREG*DATA_W-1:0] DEFAULTS = '0
) (
   input  logic                   hw_rst,
   input  logic                   sclk,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   rd_hit,
   output logic [NREG*DATA_W-1:0] regs_flat
);

   logic wr_hit;
   logic soft_rst;

   assign wr_hit   = 32'(wr_addr) < NREG;
   assign rd_hit   = 32'(rd_addr) < NREG;
   assign soft_rst = wr_en && wr_hit && (32'(wr_addr) == RST_IDX) && wr_data[RST_BIT];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge sclk or posedge hw_rst) begin
         if (hw_rst)
            q <= DEFAULTS[g*DATA_W +: DATA_W];
         else if (soft_rst)
            q <= DEFAULTS[g*DATA_W +: DATA_W];
         else if (wr_en && wr_hit && (32'(wr_addr) == 32'(g)))
            q <= wr_data;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (32'(rd_addr) == 32'(i))
            rd_data = regs_flat[i*DATA_W +: DATA_W];
   end

   // R2
   quiet_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      !wr_en |=> $stable(regs_flat));

   // R11
   hole_wr_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      (wr_en && !wr_hit) |=> $stable(regs_flat));

   // R9
   soft_rst_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      soft_rst |=> (regs_flat == DEFAULTS));

endmodule

// File: rtl/scfg_sdo.sv
module scfg_sdo
   import scfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned HDR_W  = hdr_width(ADDR_W),
   localparam int unsigned WORD_W = word_width(ADDR_W, DATA_W),
   localparam int unsigned CNT_W  = $clog2(WORD_W),
   localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
   input  logic              hw_rst,
   input  logic              sen_n,
   input  logic              sclk,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              rd_mode,
   input  logic              mark,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo,
   output logic              sdo_oe
);

   logic             clr;
   drv_e             sel;
   logic [IDX_W-1:0] bidx;
   logic             oe_q;
   logic             bit_q;

   assign clr = hw_rst | sen_n;

   // data bits leave most significant first
   assign bidx = IDX_W'(DATA_W - 1) - IDX_W'(cnt - CNT_W'(HDR_W));

   always_comb begin
      sel = DRV_OFF;
      if (rd_mode && mark && (cnt >= CNT_W'(HDR_W)))
         sel = rd_hit ? DRV_REG : DRV_HOLE;
   end

   always_ff @(negedge sclk or posedge clr) begin
      if (clr) begin
         oe_q  <= 1'b0;
         bit_q <= 1'b0;
      end else begin
         unique case (sel)
            DRV_REG: begin
               oe_q  <= 1'b1;
               bit_q <= rd_data[bidx];
            end
            DRV_HOLE: begin
               oe_q  <= 1'b1;
               bit_q <= 1'b0;
            end
            default: begin
               oe_q  <= 1'b0;
               bit_q <= 1'b0;
            end
         endcase
      end
   end

   assign sdo    = bit_q;
   assign sdo_oe = oe_q;

   // R6
   oe_win_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      oe_q |-> (cnt >= CNT_W'(HDR_W)));

   // R8
   oe_rd_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      oe_q |-> rd_mode);

endmodule

// File: rtl/scfg_top.sv
module scfg_top
   import scfg_pkg::*;
#(
   parameter int unsigned NREG    = 16,
   parameter int unsigned ADDR_W  = 14,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned RST_IDX = 6,
   parameter int unsigned RST_BIT = 0,
   parameter logic [NREG*DATA_W-1:0] DEFAULTS = 128'h00000000_00000000_00000000_3C000000
) (
   input  logic                   hw_rst,
   input  logic                   sen_n,
   input  logic                   sclk,
   input  logic                   sdi,
   output logic                   sdo,
   output logic                   sdo_oe,
   output logic [NREG*DATA_W-1:0] cfg_regs
);

   localparam int unsigned HDR_W  = hdr_width(ADDR_W);
   localparam int unsigned WORD_W = word_width(ADDR_W, DATA_W);
   localparam int unsigned CNT_W  = $clog2(WORD_W);

   initial begin
      if (DATA_W < 2)                         $error("DATA_W must be at least 2");
      if (NREG > (1 << ADDR_W))               $error("NREG exceeds address space");
      if (RST_IDX >= NREG)                    $error("RST_IDX outside bank");
      if (RST_BIT >= DATA_W)                  $error("RST_BIT outside byte");
      if (DEFAULTS[RST_IDX*DATA_W + RST_BIT]) $error("reset bit default must be 0");
   end

   logic [CNT_W-1:0]  cnt;
   logic [HDR_W-1:0]  hdr_q;
   logic              rd_mode;
   logic              word_done;
   logic [WORD_W-1:0] word;
   logic              wr_en;
   logic [DATA_W-1:0] rd_data;
   logic              rd_hit;

   scfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .hw_rst    (hw_rst),
      .sen_n     (sen_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .cnt       (cnt),
      .hdr_q     (hdr_q),
      .rd_mode   (rd_mode),
      .word_done (word_done),
      .word      (word)
   );

   // marker must be 1 and the read flag clear
   assign wr_en = word_done && word[WORD_W-2] && !rd_mode;

   scfg_regs #(
      .NREG    (NREG),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RST_IDX (RST_IDX),
      .RST_BIT (RST_BIT),
      .DEFAULTS(DEFAULTS)
   ) u_regs (
      .hw_rst    (hw_rst),
      .sclk      (sclk),
      .wr_en     (wr_en),
      .wr_addr   (word[DATA_W +: ADDR_W]),
      .wr_data   (word[DATA_W-1:0]),
      .rd_addr   (hdr_q[ADDR_W-1:0]),
      .rd_data   (rd_data),
      .rd_hit    (rd_hit),
      .regs_flat (cfg_regs)
   );

   scfg_sdo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sdo (
      .hw_rst  (hw_rst),
      .sen_n   (sen_n),
      .sclk    (sclk),
      .cnt     (cnt),
      .rd_mode (rd_mode),
      .mark    (hdr_q[ADDR_W]),
      .rd_hit  (rd_hit),
      .rd_data (rd_data),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   // R7
   wr_blk_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      wr_en |-> (!word[WORD_W-1] && !hdr_q[HDR_W-1]));

   // R5
   mark_chk: assert property (@(posedge sclk) disable iff (hw_rst)
      (word_done && !word[WORD_W-2]) |=> $stable(cfg_regs));

endmodule

// File: tb/sim_scfg_top.sv
module sim_scfg_top;

   localparam int CLK_P = 20;
   localparam int NR    = 16;

   logic sclk = 1'b0;
   logic hw_rst = 1'b1;
   logic sen_n = 1'b1;
   logic sdi = 1'b0;
   logic sdo, sdo_oe;
   logic [NR*8-1:0] cfg;

   int vectors = 0;
   int miscompares = 0;
   bit started = 1'b0;

   logic [7:0]  m_regs [NR];
   logic [23:0] wq [$];

   always #(CLK_P/2) sclk = ~sclk;

   scfg_top u0 (
      .hw_rst   (hw_rst),
      .sen_n    (sen_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .cfg_regs (cfg)
   );

   function automatic logic [7:0] dflt(input int i);
      return (i == 3) ? 8'h3C : 8'h00;
   endfunction

   function automatic logic [NR*8-1:0] dflt_flat();
      logic [NR*8-1:0] f = '0;
      for (int i = 0; i < NR; i++) f[i*8 +: 8] = dflt(i);
      return f;
   endfunction

   function automatic logic [NR*8-1:0] m_flat();
      logic [NR*8-1:0] f = '0;
      for (int i = 0; i < NR; i++) f[i*8 +: 8] = m_regs[i];
      return f;
   endfunction

   function automatic logic [23:0] mk(input bit rd, input bit mark, input int addr, input logic [7:0] d);
      return {rd, mark, addr[13:0], d};
   endfunction

   task automatic m_reset();
      for (int i = 0; i < NR; i++) m_regs[i] = dflt(i);
   endtask

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply_word(input logic [23:0] w);
      int addr = int'(w[21:8]);
      if (w[22] && !w[23] && addr < NR) begin
         if (addr == 6 && w[0]) m_reset();
         else m_regs[addr] = w[7:0];
      end
   endtask

   // shift out nbits of the queued words in one select window
   task automatic send(input int nbits);
      for (int i = 0; i < nbits; i++) begin
         logic [23:0] w = wq[i/24];
         int b = i % 24;
         int addr = int'(w[21:8]);
         @(negedge sclk);
         sen_n = 1'b0;
         sdi = w[23-b];
         #(CLK_P/4);
         if (b >= 16 && w[23] && w[22]) begin
            chk("R6 sdo_oe in read data phase", sdo_oe, 1'b1);
            if (addr < NR) chk("R6 readback bit", sdo, m_regs[addr][23-b]);
            else           chk("R11 unmapped read bit", sdo, 1'b0);
         end else begin
            chk("R8 sdo_oe off outside read data", sdo_oe, 1'b0);
         end
         @(posedge sclk);
         if (b == 23) apply_word(w);
      end
      @(negedge sclk);
      sen_n = 1'b1;
      sdi = 1'b0;
      #(CLK_P/4);
      chk("R8 sdo_oe off after window", sdo_oe, 1'b0);
      wq.delete();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // R2 whole bank against the model on every falling edge
   always @(negedge sclk)
      if (started && !hw_rst) chk("R2 register bank vs model", cfg, m_flat());

   initial begin
      #(CLK_P * 150000);
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_reset();
      repeat (4) @(posedge sclk);
      @(negedge sclk);
      #(CLK_P/4);
      chk("R10 defaults during reset", cfg, dflt_flat());
      hw_rst = 1'b0;
      started = 1'b1;
      @(negedge sclk);
      #(CLK_P/4);
      chk("R10 reg3 default", cfg[31:24], 8'h3C);
      chk("R10 sdo_oe low after reset", sdo_oe, 1'b0);

      // R2 single write
      wq.push_back(mk(0, 1, 1, 8'h5A));
      send(24);
      chk("R2 write reg1", cfg[15:8], 8'h5A);

      // R6 readback of reg1
      wq.push_back(mk(1, 1, 1, 8'h00));
      send(24);
      chk("R7 read leaves reg1", cfg[15:8], 8'h5A);

      // R3 three words in one window
      wq.push_back(mk(0, 1, 2, 8'hC3));
      wq.push_back(mk(0, 1, 4, 8'h81));
      wq.push_back(mk(0, 1, 5, 8'h7E));
      send(72);
      chk("R3 reg2", cfg[23:16], 8'hC3);
      chk("R3 reg4", cfg[39:32], 8'h81);
      chk("R3 reg5", cfg[47:40], 8'h7E);

      // R4 one bit short on the second word
      wq.push_back(mk(0, 1, 7, 8'h11));
      wq.push_back(mk(0, 1, 8, 8'hEE));
      send(47);
      chk("R4 full word applied", cfg[63:56], 8'h11);
      chk("R4 partial word dropped", cfg[71:64], 8'h00);
      wq.push_back(mk(0, 1, 9, 8'h99));
      send(24);
      chk("R4 next window from bit 0", cfg[79:72], 8'h99);

      // R5 marker clear
      wq.push_back(mk(0, 0, 1, 8'hFF));
      send(24);
      chk("R5 marker 0 ignored", cfg[15:8], 8'h5A);

      // R7 read flag blocks, then a write word clears it
      wq.push_back(mk(1, 1, 2, 8'h55));
      send(24);
      chk("R7 read word no write", cfg[23:16], 8'hC3);
      wq.push_back(mk(1, 1, 4, 8'h00));
      wq.push_back(mk(0, 1, 4, 8'h42));
      send(48);
      chk("R7 write after flag cleared", cfg[39:32], 8'h42);

      // R11 aliasing write and unmapped read
      wq.push_back(mk(0, 1, 14'h0106, 8'h01));
      wq.push_back(mk(1, 1, 14'h3FFF, 8'h00));
      send(48);
      chk("R11 alias of reset address ignored", cfg, m_flat());
      chk("R11 reg1 kept", cfg[15:8], 8'h5A);

      // R1 sdi activity while deselected
      repeat (30) begin
         @(negedge sclk);
         sdi = ~sdi;
      end
      sdi = 1'b0;
      @(negedge sclk);
      #(CLK_P/4);
      chk("R1 idle sdi no effect", cfg, m_flat());
      chk("R1 idle sdo_oe", sdo_oe, 1'b0);

      // R6 two reads in one window
      wq.push_back(mk(1, 1, 2, 8'h00));
      wq.push_back(mk(1, 1, 3, 8'h00));
      send(48);

      // R9 software reset
      wq.push_back(mk(0, 1, 6, 8'h03));
      send(24);
      chk("R9 soft reset restores defaults", cfg, dflt_flat());
      chk("R9 reset bit reads 0", cfg[55:48], 8'h00);
      wq.push_back(mk(1, 1, 6, 8'h00));
      send(24);

      // R9 bit 0 clear stores normally
      wq.push_back(mk(0, 1, 6, 8'h1C));
      send(24);
      chk("R9 write without reset bit", cfg[55:48], 8'h1C);

      // R10 hardware reset pulse
      wq.push_back(mk(0, 1, 10, 8'hAB));
      send(24);
      chk("R2 reg10", cfg[87:80], 8'hAB);
      @(negedge sclk);
      #(CLK_P/4);
      hw_rst = 1'b1;
      m_reset();
      #(CLK_P/2);
      hw_rst = 1'b0;
      @(negedge sclk);
      #(CLK_P/4);
      chk("R10 hardware reset restores defaults", cfg, dflt_flat());

      repeat (3) @(posedge sclk);
      finish_run();
   end

endmodule